// File: doc/BRIEF.md
# Floating-point deferred trap controller

This block sits beside a floating-point unit and keeps a record of every floating-point operation that has been dispatched but has not yet finished. Each dispatched operation takes a slot in an eight-entry ordered queue, which holds its instruction address and instruction word. The slot number goes back to the issuer as a tag. When the arithmetic unit completes an operation it reports the tag with the operation's IEEE flags and a denormal-operand indication. A clean completion marks the slot done, and done slots leave the queue from the oldest end.

When a completion calls for an exception, the block does not signal it at once. It records a trap type and holds the trap pending. The trap is taken later, when the next floating-point instruction (operate, load/store or branch) is announced on the arrival strobe. The faulting entry stays in the queue. A trap handler then drains the queue through a read/pop port, oldest entry first. The queue at that point holds the faulting operation and any later operations that have not completed. A dispatch attempted while a trap is pending or being handled is refused and turns the reported trap type into a sequence error.

Top module: `fpq_trap_ctrl`

## Requirements
- R1: After a synchronous reset the queue is empty (`qne` = 0), `trap_type` is 0 and `trap_req` is 0.
- R2: `qne` is 1 while at least one entry is held and 0 otherwise. Once every held operation has completed cleanly, with no trap active, the queue empties and `qne` returns to 0.
- R3: `cmpl_flags` and `trap_en` use bit 4 = invalid, bit 3 = overflow, bit 2 = underflow, bit 1 = divide-by-zero, bit 0 = inexact. A completion records trap type 1 (IEEE exception) only when a flag and its enable bit are both set. A flag whose enable bit is clear causes no trap.
- R4: With `ns_mode` = 0, a completion with `cmpl_denorm` = 1 records trap type 2 (unfinished operation), and this takes priority over IEEE flags. With `ns_mode` = 1 the denormal indication causes no trap.
- R5: A recorded exception does not raise `trap_req`. `trap_req` is a one-cycle pulse in the cycle after `fp_arrive` is sampled high while a trap is pending, and it is raised only once per exception.
- R6: After a trap, the head of the queue (`rd_addr`, `rd_insn`) is the faulting operation. The remaining entries are the later operations that had not completed, in dispatch order. Later operations that did complete are dropped automatically.
- R7: A dispatch sampled while a trap is pending or taken is not stored and sets `trap_type` to 4 (sequence error). The value 4 stays until the queue has been drained.
- R8: `trap_type` never takes the values 3, 5 or 6. Value 0 means no trap.
- R9: The queue holds at most 8 entries. `disp_tag` gives the slot that the next dispatch will use, counting up modulo 8 from 0 after reset. A dispatch while 8 entries are held is ignored.
- R10: `pop_req` has no effect unless a trap has been taken. During trap handling it removes the head entry, unless that entry is being dropped as completed in the same cycle.
- R11: Only the first exception is recorded. Exceptional completions that arrive while a trap is pending or taken leave `trap_type` unchanged, and their entries stay queued as uncompleted.
- R12: When a taken trap's queue becomes empty, `trap_type` returns to 0 one cycle later and normal dispatch resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid | input | 1 | Dispatch of a floating-point operation |
| disp_addr | input | 32 | Address of the dispatched instruction |
| disp_insn | input | 32 | Dispatched instruction word |
| disp_tag | output | 3 | Slot assigned to a dispatch in this cycle |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | 3 | Slot of the completing operation |
| cmpl_flags | input | 5 | IEEE flags of the completing operation |
| cmpl_denorm | input | 1 | Completing operation had a denormal operand |
| ns_mode | input | 1 | Non-standard mode: no unfinished-operation trap |
| trap_en | input | 5 | Per-flag IEEE trap enables |
| fp_arrive | input | 1 | A new floating-point instruction has arrived |
| pop_req | input | 1 | Handler pops the head entry |
| rd_addr | output | 32 | Address held in the head entry |
| rd_insn | output | 32 | Instruction word held in the head entry |
| qne | output | 1 | Queue not empty |
| trap_req | output | 1 | Deferred trap is taken (one-cycle pulse) |
| trap_type | output | 3 | Trap type code |

## Verification
The bound checker watches the invariants on every cycle. It checks that the reserved trap codes never show up and that a trap pulse lasts one cycle, follows an arrival strobe and carries a non-zero type. It also checks that a sequence error persists while entries remain, that reset clears the outputs, and that an accepted dispatch into an idle queue makes it non-empty. Only the directed scenarios can show the rest. These cover the order and contents of the queue after a trap, the dropping of later completed operations, the masking by enable bits and by non-standard mode, first-exception retention, the capacity limit, and pops being ignored outside trap handling.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned FLAG_W = 5;

    typedef enum logic [2:0] {
        TT_NONE   = 3'd0,
        TT_IEEE   = 3'd1,
        TT_UNFIN  = 3'd2,
        TT_UNIMP  = 3'd3,
        TT_SEQ    = 3'd4,
        TT_HWERR  = 3'd5,
        TT_BADREG = 3'd6
    } ttype_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
    } entry_t;

endpackage

// File: rtl/fpq_exc_classify.sv
module fpq_exc_classify
    import fpq_pkg::*;
(
    input  logic              valid,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] enables,
    input  logic              denorm,
    input  logic              nonstd,
    output ttype_e            code
);

    logic ieee_hit;

    always_comb begin
        ieee_hit = |(flags & enables);
        code     = TT_NONE;
        if (valid) begin
            // an unfinished operation produced no valid flags, so it wins
            if (denorm && !nonstd) begin
                code = TT_UNFIN;
            end else if (ieee_hit) begin
                code = TT_IEEE;
            end
        end
    end

endmodule

// File: rtl/fpq_entry_store.sv
module fpq_entry_store
    import fpq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  entry_t        wr_data,
    input  logic [PW-1:0] rd_idx,
    output entry_t        rd_data
);

    entry_t slot_d [DEPTH];
    entry_t slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= slot_d[i];
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/fpq_trap_ctrl.sv
module fpq_trap_ctrl
    import fpq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic [INSN_W-1:0] disp_insn,
    output logic [PW-1:0]     disp_tag,
    input  logic              cmpl_valid,
    input  logic [PW-1:0]     cmpl_tag,
    input  logic [FLAG_W-1:0] cmpl_flags,
    input  logic              cmpl_denorm,
    input  logic              ns_mode,
    input  logic [FLAG_W-1:0] trap_en,
    input  logic              fp_arrive,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [INSN_W-1:0] rd_insn,
    output logic              qne,
    output logic              trap_req,
    output logic [2:0]        trap_type
);

    typedef struct packed {
        logic [PW-1:0]    head;
        logic [PW-1:0]    tail;
        logic [CW-1:0]    count;
        logic [DEPTH-1:0] done;
        logic             pend;
        logic             taken;
        logic             trap_req;
        ttype_e           ttype;
    } state_t;

    state_t s_d, s_q;

    ttype_e exc_code;
    entry_t wr_entry;
    entry_t head_entry;

    logic trap_mode;
    logic accept;
    logic reject;
    logic retire;
    logic pop_ok;
    logic remove;
    logic drain_done;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    fpq_exc_classify u_classify (
        .valid   (cmpl_valid),
        .flags   (cmpl_flags),
        .enables (trap_en),
        .denorm  (cmpl_denorm),
        .nonstd  (ns_mode),
        .code    (exc_code)
    );

    assign wr_entry = '{addr: disp_addr, insn: disp_insn};

    fpq_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (s_q.tail),
        .wr_data (wr_entry),
        .rd_idx  (s_q.head),
        .rd_data (head_entry)
    );

    always_comb begin
        s_d          = s_q;
        s_d.trap_req = 1'b0;

        trap_mode  = s_q.pend || s_q.taken;
        accept     = disp_valid && !trap_mode && (s_q.count != CW'(DEPTH));
        reject     = disp_valid && trap_mode;
        retire     = (s_q.count != '0) && s_q.done[s_q.head];
        pop_ok     = pop_req && s_q.taken && (s_q.count != '0) && !retire;
        remove     = retire || pop_ok;
        drain_done = s_q.taken && (s_q.count == '0);

        // queue bookkeeping
        if (accept) begin
            s_d.done[s_q.tail] = 1'b0;
            s_d.tail           = ptr_inc(s_q.tail);
        end
        if (cmpl_valid && (exc_code == TT_NONE)) begin
            s_d.done[cmpl_tag] = 1'b1;
        end
        if (remove) begin
            s_d.head = ptr_inc(s_q.head);
        end
        s_d.count = s_q.count + CW'(accept) - CW'(remove);

        // exception recording: first one only
        if (!trap_mode && (exc_code != TT_NONE)) begin
            s_d.pend  = 1'b1;
            s_d.ttype = exc_code;
        end

        // deferred signalling on the next arriving FP instruction
        if (s_q.pend && fp_arrive) begin
            s_d.pend     = 1'b0;
            s_d.taken    = 1'b1;
            s_d.trap_req = 1'b1;
        end

        if (drain_done) begin
            s_d.taken = 1'b0;
            s_d.ttype = TT_NONE;
        end else if (reject) begin
            s_d.ttype = TT_SEQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{head: '0, tail: '0, count: '0, done: '0,
                     pend: 1'b0, taken: 1'b0, trap_req: 1'b0, ttype: TT_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_tag  = s_q.tail;
    assign rd_addr   = head_entry.addr;
    assign rd_insn   = head_entry.insn;
    assign qne       = (s_q.count != '0);
    assign trap_req  = s_q.trap_req;
    assign trap_type = s_q.ttype;

endmodule

// File: rtl/fpq_trap_ctrl_chk.sv
module fpq_trap_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       disp_valid,
    input logic       fp_arrive,
    input logic       qne,
    input logic       trap_req,
    input logic [2:0] trap_type
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!qne && !trap_req && (trap_type == 3'd0)));

    // R8
    no_reserved_type_chk: assert property (@(posedge clk) disable iff (rst)
        !(trap_type inside {3'd3, 3'd5, 3'd6}));

    // R5
    trap_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req);

    // R5
    trap_after_arrive_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> ($past(fp_arrive) && (trap_type != 3'd0)));

    // R7
    seq_error_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((trap_type == 3'd4) && qne) |=> (trap_type == 3'd4));

    // R2
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !qne && (trap_type == 3'd0)) |=> qne);

endmodule

bind fpq_trap_ctrl fpq_trap_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .fp_arrive  (fp_arrive),
    .qne        (qne),
    .trap_req   (trap_req),
    .trap_type  (trap_type)
);

// File: tb/fpq_trap_ctrl_bench.sv
`timescale 1ns/1ps
module fpq_trap_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        disp_valid;
    logic [31:0] disp_addr;
    logic [31:0] disp_insn;
    logic [2:0]  disp_tag;
    logic        cmpl_valid;
    logic [2:0]  cmpl_tag;
    logic [4:0]  cmpl_flags;
    logic        cmpl_denorm;
    logic        ns_mode;
    logic [4:0]  trap_en;
    logic        fp_arrive;
    logic        pop_req;
    logic [31:0] rd_addr;
    logic [31:0] rd_insn;
    logic        qne;
    logic        trap_req;
    logic [2:0]  trap_type;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fpq_trap_ctrl u_fpq_trap_ctrl (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_addr(disp_addr), .disp_insn(disp_insn),
        .disp_tag(disp_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_flags(cmpl_flags),
        .cmpl_denorm(cmpl_denorm), .ns_mode(ns_mode), .trap_en(trap_en),
        .fp_arrive(fp_arrive), .pop_req(pop_req),
        .rd_addr(rd_addr), .rd_insn(rd_insn), .qne(qne),
        .trap_req(trap_req), .trap_type(trap_type)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic dispatch(input logic [31:0] a, output logic [2:0] tag);
        disp_valid = 1'b1;
        disp_addr  = a;
        disp_insn  = ~a;
        tag        = disp_tag;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic complete(input logic [2:0] tag, input logic [4:0] fl, input logic dn);
        cmpl_valid  = 1'b1;
        cmpl_tag    = tag;
        cmpl_flags  = fl;
        cmpl_denorm = dn;
        step();
        cmpl_valid  = 1'b0;
        cmpl_flags  = '0;
        cmpl_denorm = 1'b0;
    endtask

    task automatic arrive();
        fp_arrive = 1'b1;
        step();
        fp_arrive = 1'b0;
    endtask

    task automatic pop();
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 qne", {31'd0, qne}, 32'd0);
        chk("R1 trap_type", {29'd0, trap_type}, 32'd0);
        chk("R1 trap_req", {31'd0, trap_req}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_clean();
        logic [2:0] t0, t1, t2;
        dispatch(32'h100, t0);
        dispatch(32'h104, t1);
        dispatch(32'h108, t2);
        chk("R9 tag0", {29'd0, t0}, 32'd0);
        chk("R9 tag2", {29'd0, t2}, 32'd2);
        chk("R2 qne set", {31'd0, qne}, 32'd1);
        chk("R6 head order", rd_addr, 32'h100);
        complete(t1, 5'd0, 1'b0);
        complete(t2, 5'd0, 1'b0);
        complete(t0, 5'd0, 1'b0);
        repeat (4) step();
        chk("R2 qne clear", {31'd0, qne}, 32'd0);
        chk("R2 no trap", {29'd0, trap_type}, 32'd0);
    endtask

    task automatic t_masked_and_pop();
        logic [2:0] t;
        trap_en = 5'b00000;
        dispatch(32'h200, t);
        pop();
        chk("R10 pop ignored qne", {31'd0, qne}, 32'd1);
        chk("R10 pop ignored head", rd_addr, 32'h200);
        complete(t, 5'b10000, 1'b0);
        chk("R3 masked flag", {29'd0, trap_type}, 32'd0);
        repeat (2) step();
        chk("R3 masked drained", {31'd0, qne}, 32'd0);
    endtask

    task automatic t_ieee();
        logic [2:0] ta, tb, tc;
        trap_en = 5'b10000;
        ns_mode = 1'b0;
        dispatch(32'h300, ta);
        dispatch(32'h304, tb);
        dispatch(32'h308, tc);
        complete(tb, 5'd0, 1'b0);
        complete(ta, 5'b10000, 1'b0);
        chk("R3 ieee type", {29'd0, trap_type}, 32'd1);
        chk("R5 no immediate trap", {31'd0, trap_req}, 32'd0);
        repeat (3) step();
        chk("R5 still deferred", {31'd0, trap_req}, 32'd0);
        complete(tc, 5'd0, 1'b1);
        chk("R11 first kept", {29'd0, trap_type}, 32'd1);
        arrive();
        chk("R5 trap pulse", {31'd0, trap_req}, 32'd1);
        chk("R5 trap type", {29'd0, trap_type}, 32'd1);
        step();
        chk("R5 pulse ends", {31'd0, trap_req}, 32'd0);
        chk("R6 fault at head", rd_addr, 32'h300);
        chk("R6 fault insn", rd_insn, ~32'h300);
        pop();
        step();
        chk("R6 completed dropped", rd_addr, 32'h308);
        chk("R11 entry kept", {31'd0, qne}, 32'd1);
        pop();
        chk("R6 drained", {31'd0, qne}, 32'd0);
        step();
        chk("R12 type clears", {29'd0, trap_type}, 32'd0);
    endtask

    task automatic t_unfinished();
        logic [2:0] t;
        trap_en = 5'b00000;
        ns_mode = 1'b0;
        dispatch(32'h400, t);
        complete(t, 5'd0, 1'b1);
        chk("R4 unfinished", {29'd0, trap_type}, 32'd2);
        arrive();
        chk("R4 trap taken", {31'd0, trap_req}, 32'd1);
        pop();
        step();
        chk("R12 clear after drain", {29'd0, trap_type}, 32'd0);
        ns_mode = 1'b1;
        dispatch(32'h404, t);
        complete(t, 5'd0, 1'b1);
        chk("R4 nonstd no trap", {29'd0, trap_type}, 32'd0);
        repeat (2) step();
        chk("R4 nonstd drained", {31'd0, qne}, 32'd0);
        ns_mode = 1'b0;
    endtask

    task automatic t_sequence();
        logic [2:0] t, tr;
        trap_en = 5'b11111;
        dispatch(32'h500, t);
        complete(t, 5'b01000, 1'b0);
        chk("R3 overflow enabled", {29'd0, trap_type}, 32'd1);
        dispatch(32'h504, tr);
        chk("R7 seq error", {29'd0, trap_type}, 32'd4);
        arrive();
        chk("R7 trap reports seq", {29'd0, trap_type}, 32'd4);
        chk("R7 trap pulse", {31'd0, trap_req}, 32'd1);
        chk("R7 head is fault", rd_addr, 32'h500);
        pop();
        chk("R7 rejected not stored", {31'd0, qne}, 32'd0);
        step();
        chk("R12 seq cleared", {29'd0, trap_type}, 32'd0);
    endtask

    task automatic t_capacity();
        logic [2:0] first, t;
        trap_en = 5'b11111;
        dispatch(32'h600, first);
        for (int k = 1; k < 8; k++) begin
            dispatch(32'h600 + 32'(k * 4), t);
        end
        dispatch(32'hDEAD0000, t);
        chk("R9 head after overflow", rd_addr, 32'h600);
        complete(first, 5'b00010, 1'b0);
        arrive();
        chk("R9 trap", {31'd0, trap_req}, 32'd1);
        for (int k = 0; k < 8; k++) begin
            chk("R9 R6 drain order", rd_addr, 32'h600 + 32'(k * 4));
            pop();
        end
        chk("R9 exactly eight", {31'd0, qne}, 32'd0);
        step();
        chk("R12 final clear", {29'd0, trap_type}, 32'd0);
    endtask

    initial begin
        rst = 1'b1;
        disp_valid = 1'b0; disp_addr = '0; disp_insn = '0;
        cmpl_valid = 1'b0; cmpl_tag = '0; cmpl_flags = '0; cmpl_denorm = 1'b0;
        ns_mode = 1'b0; trap_en = '0; fp_arrive = 1'b0; pop_req = 1'b0;
        t_reset();
        t_clean();
        t_masked_and_pop();
        t_ieee();
        t_unfinished();
        t_sequence();
        t_capacity();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule